// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block drives the secondary trigger line of a timer that acts as master for slave timers or an ADC. A 4-bit mode input chooses what the line carries. It can carry one of four timer events: the software update strobe, the counter-enable level, the update event, or the channel-1 capture/compare flag-set strobe. It can carry the level of one of six compare references. It can also carry single-cycle pulses built from edges of references 4, 5 and 6.

In the pulse modes, the block compares each tracked reference with a copy registered on the previous clock. Several of these modes merge two references, and for each reference they pick either its rising or its falling edge. The output is registered, so in every mode the trigger appears one clock after the condition that causes it. The mode can be changed at any time and takes effect on the next clock. The edge history keeps updating whatever the mode.

Top module: `trg_master_out`

## Requirements
- R1: While reset is low the trigger is 0. Reset clears the edge history. On the first clock after reset no edge pulse is generated, whatever the reference levels.
- R2: Mode 4'b0000 forwards the software update strobe `ug_i` to `trig_o` one clock later.
- R3: Mode 4'b0001 forwards the counter-enable level `cnt_en_i` to `trig_o` one clock later.
- R4: Mode 4'b0010 forwards the update event `update_i` to `trig_o` one clock later.
- R5: Mode 4'b0011 forwards the channel-1 flag-set strobe `cc1_set_i` to `trig_o` one clock later. Every strobe gives a pulse.
- R6: Modes 4'b0100 to 4'b1001 forward the level of reference 1 to 6 respectively to `trig_o` one clock later. Reference n is `ref_i[n-1]`.
- R7: Mode 4'b1010 gives a one-cycle pulse for every rising or falling edge of reference 4. Mode 4'b1011 does the same for reference 6. Edges of other references have no effect.
- R8: Mode 4'b1100 pulses on a rising edge of reference 4 or of reference 6. Mode 4'b1101 pulses on a rising edge of reference 4 or a falling edge of reference 6.
- R9: Mode 4'b1110 pulses on a rising edge of reference 5 or of reference 6. Mode 4'b1111 pulses on a rising edge of reference 5 or a falling edge of reference 6.
- R10: Qualifying edges on both references of a two-reference mode in the same cycle produce one pulse of a single cycle.
- R11: A mode change takes effect on the next clock. The edge history updates in every mode, so an edge seen while a level mode was selected gives no pulse after a switch to a pulse mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 4 | Trigger source selection |
| ug_i | input | 1 | Software update-generate strobe |
| cnt_en_i | input | 1 | Counter enable level |
| update_i | input | 1 | Update event |
| cc1_set_i | input | 1 | Channel-1 capture/compare flag-set strobe |
| ref_i | input | NUM_REF (6) | Compare reference levels; bit n-1 is reference n |
| trig_o | output | 1 | Registered trigger output |

## Verification
The bench builds the block with its default NUM_REF of 6. This places the edge-tracked references 4, 5 and 6 on `ref_i[5:3]`, so every mode code from 4'b0000 to 4'b1111 has a real signal behind it. With that setting, directed scenarios reach each level mode and each edge combination. They include simultaneous edges on both references and an edge made while a level mode was selected. They also cover the first clock after reset with all references already high.

// File: rtl/trg_pkg.sv
package trg_pkg;

  localparam int TRG_MODE_W = 4;
  localparam int TRG_TRACK_W = 3;

  typedef enum logic [TRG_MODE_W-1:0] {
    TM_SWUPD   = 4'b0000,
    TM_CNTEN   = 4'b0001,
    TM_UPDATE  = 4'b0010,
    TM_CCPULSE = 4'b0011,
    TM_LVL1    = 4'b0100,
    TM_LVL2    = 4'b0101,
    TM_LVL3    = 4'b0110,
    TM_LVL4    = 4'b0111,
    TM_LVL5    = 4'b1000,
    TM_LVL6    = 4'b1001,
    TM_ANY4    = 4'b1010,
    TM_ANY6    = 4'b1011,
    TM_R4R6    = 4'b1100,
    TM_R4F6    = 4'b1101,
    TM_R5R6    = 4'b1110,
    TM_R5F6    = 4'b1111
  } trg_mode_e;

endpackage

// File: rtl/trg_hist_reg.sv
module trg_hist_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] hist_o,
  output logic         primed_o
);

  logic [W-1:0] hist_d, hist_q;
  logic         primed_d, primed_q;

  always_comb begin
    hist_d   = cur_i;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      primed_q <= primed_d;
    end
  end

  assign hist_o   = hist_q;
  assign primed_o = primed_q;

  // R11: history follows the references every cycle, whatever the mode
  a_r11_hist_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> hist_q == $past(cur_i));

endmodule

// File: rtl/trg_pulse_sel.sv
module trg_pulse_sel
  import trg_pkg::*;
(
  input  trg_mode_e               mode_i,
  input  logic [TRG_TRACK_W-1:0]  cur_i,
  input  logic [TRG_TRACK_W-1:0]  hist_i,
  input  logic                    primed_i,
  output logic                    pulse_o
);

  // index 0: reference 4, 1: reference 5, 2: reference 6
  logic [TRG_TRACK_W-1:0] rise, fall;

  for (genvar g = 0; g < TRG_TRACK_W; g++) begin : g_edge
    assign rise[g] = primed_i &  cur_i[g] & ~hist_i[g];
    assign fall[g] = primed_i & ~cur_i[g] &  hist_i[g];
  end

  always_comb begin
    unique case (mode_i)
      TM_ANY4: pulse_o = rise[0] | fall[0];
      TM_ANY6: pulse_o = rise[2] | fall[2];
      TM_R4R6: pulse_o = rise[0] | rise[2];
      TM_R4F6: pulse_o = rise[0] | fall[2];
      TM_R5R6: pulse_o = rise[1] | rise[2];
      TM_R5F6: pulse_o = rise[1] | fall[2];
      default: pulse_o = 1'b0;
    endcase
  end

  // fall of reference 5 is never a qualifying edge
  logic unused_fall5;
  assign unused_fall5 = fall[1];

endmodule

// File: rtl/trg_master_out.sv
module trg_master_out
  import trg_pkg::*;
#(
  parameter int NUM_REF = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TRG_MODE_W-1:0] mode_i,
  input  logic                  ug_i,
  input  logic                  cnt_en_i,
  input  logic                  update_i,
  input  logic                  cc1_set_i,
  input  logic [NUM_REF-1:0]    ref_i,
  output logic                  trig_o
);

  localparam int TRK_LO = NUM_REF - TRG_TRACK_W;

  trg_mode_e              mode_e;
  logic [TRG_TRACK_W-1:0] hist;
  logic                   primed;
  logic                   pulse;
  logic                   trig_d, trig_q;

  assign mode_e = trg_mode_e'(mode_i);

  trg_hist_reg #(.W(TRG_TRACK_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_i    (ref_i[NUM_REF-1:TRK_LO]),
    .hist_o   (hist),
    .primed_o (primed)
  );

  trg_pulse_sel u_pulse (
    .mode_i   (mode_e),
    .cur_i    (ref_i[NUM_REF-1:TRK_LO]),
    .hist_i   (hist),
    .primed_i (primed),
    .pulse_o  (pulse)
  );

  always_comb begin
    unique case (mode_e)
      TM_SWUPD:   trig_d = ug_i;
      TM_CNTEN:   trig_d = cnt_en_i;
      TM_UPDATE:  trig_d = update_i;
      TM_CCPULSE: trig_d = cc1_set_i;
      TM_LVL1:    trig_d = ref_i[0];
      TM_LVL2:    trig_d = ref_i[1];
      TM_LVL3:    trig_d = ref_i[2];
      TM_LVL4:    trig_d = ref_i[3];
      TM_LVL5:    trig_d = ref_i[4];
      TM_LVL6:    trig_d = ref_i[5];
      default:    trig_d = pulse;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig_o = trig_q;

  // R1: first clock after reset never yields an edge pulse
  a_r1_first_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!primed && mode_i >= 4'b1010) |=> !trig_o);

  // R4: update event appears one clock later
  a_r4_update_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0010) |=> trig_o == $past(update_i));

  // R5: every flag-set strobe becomes a pulse
  a_r5_cc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0011 && cc1_set_i) |=> trig_o);

  // R6: reference 1 level mode
  a_r6_level_ref1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0100) |=> trig_o == $past(ref_i[0]));

  // R7: any change of reference 4 yields a pulse in mode 4'b1010
  a_r7_any_edge4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b1010 && primed && ref_i[TRK_LO] != hist[0]) |=> trig_o);

endmodule

// File: tb/tb_trg_master_out.sv
`timescale 1ns/1ps
module tb_trg_master_out;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode;
  logic       ug, cnt_en, upd, cc1;
  logic [5:0] refs;
  logic       trig;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  trg_master_out #(.NUM_REF(6)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ug_i(ug), .cnt_en_i(cnt_en),
    .update_i(upd), .cc1_set_i(cc1), .ref_i(refs), .trig_o(trig)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trig=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input logic [3:0] m, input logic [5:0] r);
    mode = m; refs = r;
    tick(); tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 4'b1100; refs = 6'h3F;
    ug = 0; cnt_en = 0; upd = 0; cc1 = 0;
    tick(); tick();
    check("R1 in reset", trig, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 first clock", trig, 1'b0);
    tick();
    check("R1 second clock", trig, 1'b0);
  endtask

  task automatic t_events();
    settle(4'b0000, 6'h00);
    ug = 1; tick(); check("R2 ug high", trig, 1'b1);
    ug = 0; tick(); check("R2 ug low", trig, 1'b0);
    mode = 4'b0001; cnt_en = 1; tick(); check("R3 cnt_en high", trig, 1'b1);
    ug = 1; cnt_en = 0; tick(); check("R3 cnt_en low", trig, 1'b0);
    ug = 0;
    mode = 4'b0010; upd = 1; tick(); check("R4 update high", trig, 1'b1);
    upd = 0; tick(); check("R4 update low", trig, 1'b0);
    mode = 4'b0011; cc1 = 1; tick(); check("R5 strobe 1", trig, 1'b1);
    cc1 = 0; tick(); check("R5 gap", trig, 1'b0);
    cc1 = 1; tick(); check("R5 strobe 2", trig, 1'b1);
    cc1 = 0; tick(); check("R5 end", trig, 1'b0);
  endtask

  task automatic t_levels();
    for (int k = 0; k < 6; k++) begin
      mode = 4'(4 + k);
      refs = 6'(1 << k); tick(); check("R6 level high", trig, 1'b1);
      refs = ~6'(1 << k); tick(); check("R6 level low", trig, 1'b0);
    end
  endtask

  task automatic t_any_edge();
    settle(4'b1010, 6'h00);
    refs[3] = 1; tick(); check("R7 ref4 rise", trig, 1'b1);
    tick(); check("R7 one cycle", trig, 1'b0);
    refs[3] = 0; tick(); check("R7 ref4 fall", trig, 1'b1);
    tick(); check("R7 fall end", trig, 1'b0);
    refs[5] = 1; tick(); check("R7 ref6 ignored", trig, 1'b0);
    settle(4'b1011, 6'h00);
    refs[5] = 1; tick(); check("R7 ref6 rise", trig, 1'b1);
    refs[5] = 0; tick(); check("R7 ref6 fall", trig, 1'b1);
    tick(); check("R7 ref6 end", trig, 1'b0);
  endtask

  task automatic t_pair46();
    settle(4'b1100, 6'h00);
    refs[5] = 1; tick(); check("R8 r4r6 ref6 rise", trig, 1'b1);
    refs[5] = 0; tick(); check("R8 r4r6 ref6 fall", trig, 1'b0);
    refs[3] = 1; tick(); check("R8 r4r6 ref4 rise", trig, 1'b1);
    refs[3] = 0; tick(); check("R8 r4r6 ref4 fall", trig, 1'b0);
    settle(4'b1101, 6'h20);
    refs[5] = 0; tick(); check("R8 r4f6 ref6 fall", trig, 1'b1);
    refs[5] = 1; tick(); check("R8 r4f6 ref6 rise", trig, 1'b0);
    refs[3] = 1; tick(); check("R8 r4f6 ref4 rise", trig, 1'b1);
    refs[3] = 0; tick(); check("R8 r4f6 ref4 fall", trig, 1'b0);
  endtask

  task automatic t_pair56();
    settle(4'b1110, 6'h00);
    refs[4] = 1; tick(); check("R9 r5r6 ref5 rise", trig, 1'b1);
    refs[4] = 0; tick(); check("R9 r5r6 ref5 fall", trig, 1'b0);
    refs[5] = 1; tick(); check("R9 r5r6 ref6 rise", trig, 1'b1);
    refs[3] = 1; tick(); check("R9 r5r6 ref4 ignored", trig, 1'b0);
    settle(4'b1111, 6'h20);
    refs[5] = 0; tick(); check("R9 r5f6 ref6 fall", trig, 1'b1);
    refs[4] = 1; tick(); check("R9 r5f6 ref5 rise", trig, 1'b1);
    refs[4] = 0; tick(); check("R9 r5f6 ref5 fall", trig, 1'b0);
  endtask

  task automatic t_simultaneous();
    settle(4'b1100, 6'h00);
    refs = 6'h28; tick(); check("R10 both rise", trig, 1'b1);
    tick(); check("R10 single cycle", trig, 1'b0);
    settle(4'b1111, 6'h20);
    refs = 6'h10; tick(); check("R10 rise5 fall6", trig, 1'b1);
    tick(); check("R10 single cycle 2", trig, 1'b0);
  endtask

  task automatic t_mode_switch();
    settle(4'b0010, 6'h01);
    upd = 0;
    mode = 4'b0100; tick(); check("R11 switch takes effect", trig, 1'b1);
    refs = 6'h00; tick(); check("R11 level low", trig, 1'b0);
    refs[3] = 1; tick(); check("R11 edge in level mode", trig, 1'b0);
    mode = 4'b1010; tick(); check("R11 no stale pulse", trig, 1'b0);
    refs[3] = 0; tick(); check("R11 fresh edge", trig, 1'b1);
  endtask

  initial begin
    t_reset();
    t_events();
    t_levels();
    t_any_edge();
    t_pair46();
    t_pair56();
    t_simultaneous();
    t_mode_switch();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule